// File: doc/BRIEF.md
# Sample-Count to Timebase Mapper

This block places every sample of an acquisition stream on a disciplined time axis. It counts sample strobes and keeps a linear model of time against sample count: a fixed-point ratio (timebase ticks per sample) and an anchor point (sample index, timebase time). A sync marker that has been captured both as a sample index and as a timebase timestamp is presented as an anchor pair. Each accepted pair first yields a residual, which is the observed anchor time minus the time the current model predicts for that index. The pair then refreshes the model.

The ratio is recomputed from the two most recent accepted anchors by a bit-serial divider. When the division finishes, a phase accumulator is reloaded to the model's time for the current sample. From then on it adds the ratio once per strobe, so the timestamp advances smoothly between anchors. The status reads unlocked until a ratio exists. It reads locked while anchors keep arriving, and holdover once a programmed number of strobes passes without one. In holdover the coefficients stay frozen and timestamps keep flowing. Anchor pairs must already be in the block's clock domain.

Top module: `stamp_mapper`

## Requirements
- R1: After reset the status is unlocked (code 0), the timestamp-valid flag, the residual-valid pulse, the sample index and the error count are all zero.
- R2: Each cycle with the sample strobe high raises the sample index by one and advances the timestamp by the ratio. Timestamps never decrease between reloads.
- R3: The ratio is floor((t_new - t_old) * 2^32 / (n_new - n_old)) taken modulo 2^48 (16 integer bits and 32 fraction bits), from the two latest accepted anchors. After a reload, the timestamp for sample n is bits [79:32] of (t_new * 2^32 + ratio * (n - n_new)), with n - n_new taken modulo 2^32.
- R4: The status stays unlocked, and the timestamp is flagged invalid, until the ratio from the second accepted anchor has been loaded. The status then becomes locked (code 1).
- R5: An anchor accepted while coefficients exist produces a residual: observed time minus predicted time, using the coefficients in force before that anchor. It is a two's-complement value with a valid pulse of exactly one cycle, in the cycle after the anchor. Anchors accepted before the first ratio produce no residual.
- R6: An anchor whose index equals the previous accepted anchor's index is rejected. It changes no model state and raises the error count by one, saturating.
- R7: An anchor presented while a ratio update is in progress is ignored. It produces no residual and no error, and it does not alter the model.
- R8: When the status is locked and the number of strobes since the last accepted anchor reaches the hold limit, the status becomes holdover (code 2) one cycle later. Timestamps keep advancing with the frozen ratio and stay valid.
- R9: An accepted anchor during holdover returns the status to locked in the next cycle and restarts the strobe count.
- R10: A strobe in the same cycle as a ratio reload is included in the reloaded timestamp, so no sample is lost or counted twice.
- R11: Residuals beyond the signed 32-bit range saturate to 0x7FFFFFFF or 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One pulse per sample |
| anc_vld | input | 1 | Anchor pair present |
| anc_idx | input | IDX_W | Sample index captured at the marker |
| anc_time | input | TS_W | Timebase time captured at the marker |
| hold_limit | input | HC_W | Strobes without an anchor before holdover |
| smp_idx | output | IDX_W | Current sample index |
| ts_out | output | TS_W | Timestamp of the current sample (integer ticks) |
| ts_valid | output | 1 | Timestamp is meaningful |
| resid | output | RES_W | Signed residual of the last anchor |
| resid_vld | output | 1 | One-cycle pulse with a new residual |
| map_state | output | 2 | 0 unlocked, 1 locked, 2 holdover |
| err_cnt | output | ERR_W | Count of rejected zero-delta anchors |

## Verification
The two functions that can fall in one cycle are the end of a ratio division, which reloads the accumulator, and a sample strobe, which would normally add the old ratio. The bench drives the strobe high on every cycle across the whole division window after an anchor. Whatever cycle the reload lands in, it therefore coincides with a strobe. The timestamp and sample index read afterwards are compared with the linear model evaluated at the total strobe count, so a lost or doubled increment shows up as a mismatch of at least one ratio step.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

   typedef enum logic [1:0] {
      ST_UNLOCK = 2'b00,
      ST_LOCK   = 2'b01,
      ST_HOLD   = 2'b10
   } map_state_e;

endpackage

// File: rtl/mapper_div.sv
module mapper_div #(
   parameter int NUM_W = 80,
   parameter int DEN_W = 32,
   parameter int Q_W   = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             done,
   output logic [Q_W-1:0]   quo
);
   localparam int CW = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] num_sh, num_r, quo_r;
   logic [DEN_W-1:0] den_r, rem;
   logic [CW-1:0]    step;
   logic [DEN_W:0]   rem_sh;
   logic             fits;

   assign rem_sh = {rem, num_sh[NUM_W-1]};
   assign fits   = rem_sh >= {1'b0, den_r};
   assign quo    = quo_r[Q_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         num_sh <= '0;
         num_r  <= '0;
         quo_r  <= '0;
         den_r  <= '0;
         rem    <= '0;
         step   <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy   <= 1'b1;
            num_sh <= num;
            num_r  <= num;
            den_r  <= den;
            rem    <= '0;
            quo_r  <= '0;
            step   <= '0;
         end else if (busy) begin
            rem    <= fits ? DEN_W'(rem_sh - {1'b0, den_r}) : rem_sh[DEN_W-1:0];
            quo_r  <= {quo_r[NUM_W-2:0], fits};
            num_sh <= {num_sh[NUM_W-2:0], 1'b0};
            step   <= step + 1'b1;
            if (step == CW'(NUM_W - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // quotient check for the ratio (R3)
   localparam int PW = NUM_W + DEN_W;
   logic [PW-1:0] chk_prod;
   assign chk_prod = PW'(quo_r) * PW'(den_r);

   a_r3_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (chk_prod <= PW'(num_r)) && ((PW'(num_r) - chk_prod) < PW'(den_r)));

   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/mapper_acc.sv
module mapper_acc #(
   parameter int IDX_W = 32,
   parameter int TS_W  = 48,
   parameter int R_W   = 48,
   parameter int RF_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic             load,
   input  logic [R_W-1:0]   ratio,
   input  logic [R_W-1:0]   load_ratio,
   input  logic [TS_W-1:0]  base_time,
   input  logic [IDX_W-1:0] base_idx,
   output logic [IDX_W-1:0] idx,
   output logic [TS_W-1:0]  ts
);
   localparam int ACC_W = TS_W + RF_W;

   logic [ACC_W-1:0] acc, reload_val;
   logic [IDX_W-1:0] n_next, dn;

   assign n_next     = idx + IDX_W'(stb);
   assign dn         = n_next - base_idx;
   assign reload_val = {base_time, {RF_W{1'b0}}} + ACC_W'(load_ratio) * ACC_W'(dn);
   assign ts         = acc[ACC_W-1:RF_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         idx <= '0;
      end else begin
         idx <= n_next;
         if (load)
            acc <= reload_val;
         else if (stb)
            acc <= acc + ACC_W'(ratio);
      end
   end

   a_r2_ts_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !load) |=> (ts >= $past(ts)));

endmodule

// File: rtl/mapper_hold.sv
module mapper_hold #(
   parameter int HC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            stb,
   input  logic [HC_W-1:0] limit,
   output logic            expired
);
   logic [HC_W-1:0] cnt;

   assign expired = cnt >= limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (stb && cnt != '1)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/mapper_sat.sv
module mapper_sat #(
   parameter int IN_W  = 49,
   parameter int OUT_W = 32
) (
   input  logic signed [IN_W-1:0]  d,
   output logic signed [OUT_W-1:0] q
);
   generate
      if (OUT_W >= IN_W) begin : g_pass
         assign q = OUT_W'(d);
      end else begin : g_clip
         localparam logic signed [IN_W-1:0] HI =
            {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
         localparam logic signed [IN_W-1:0] LO =
            {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
         always_comb begin
            if (d > HI)
               q = HI[OUT_W-1:0];
            else if (d < LO)
               q = LO[OUT_W-1:0];
            else
               q = d[OUT_W-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/stamp_mapper.sv
module stamp_mapper
   import mapper_pkg::*;
#(
   parameter int IDX_W = 32,
   parameter int TS_W  = 48,
   parameter int RI_W  = 16,
   parameter int RF_W  = 32,
   parameter int RES_W = 32,
   parameter int HC_W  = 16,
   parameter int ERR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_stb,
   input  logic             anc_vld,
   input  logic [IDX_W-1:0] anc_idx,
   input  logic [TS_W-1:0]  anc_time,
   input  logic [HC_W-1:0]  hold_limit,
   output logic [IDX_W-1:0] smp_idx,
   output logic [TS_W-1:0]  ts_out,
   output logic             ts_valid,
   output logic [RES_W-1:0] resid,
   output logic             resid_vld,
   output logic [1:0]       map_state,
   output logic [ERR_W-1:0] err_cnt
);
   localparam int R_W   = RI_W + RF_W;
   localparam int ACC_W = TS_W + RF_W;

   generate
      if (RF_W < 1 || RI_W < 1) begin : g_bad_ratio
         $error("ratio needs integer and fraction bits");
      end
      if (R_W > ACC_W || IDX_W > ACC_W) begin : g_bad_width
         $error("ratio or index wider than accumulator");
      end
      if (RES_W < 2) begin : g_bad_res
         $error("residual too narrow");
      end
   endgenerate

   map_state_e       st;
   logic [1:0]       seen;
   logic             coef_ok;
   logic [IDX_W-1:0] prev_idx, delta_n;
   logic [TS_W-1:0]  prev_time, pred_t;
   logic [R_W-1:0]   ratio, div_q;
   logic             div_busy, div_done, upd_busy;
   logic             anc_take, zero_rej, acc_ok, div_go, hold_exp;
   logic [ACC_W-1:0] div_num, pred_full;
   logic signed [TS_W:0]    diff;
   logic signed [RES_W-1:0] resid_sat;

   assign upd_busy  = div_busy | div_done;
   assign delta_n   = anc_idx - prev_idx;
   assign anc_take  = anc_vld & ~upd_busy;
   assign zero_rej  = anc_take && (seen != 2'd0) && (delta_n == '0);
   assign acc_ok    = anc_take & ~zero_rej;
   assign div_go    = acc_ok && (seen != 2'd0);
   assign div_num   = {anc_time - prev_time, {RF_W{1'b0}}};
   assign pred_full = {prev_time, {RF_W{1'b0}}} + ACC_W'(ratio) * ACC_W'(delta_n);
   assign pred_t    = pred_full[ACC_W-1:RF_W];
   assign diff      = $signed({1'b0, anc_time}) - $signed({1'b0, pred_t});

   mapper_div #(.NUM_W(ACC_W), .DEN_W(IDX_W), .Q_W(R_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_go), .num(div_num), .den(delta_n),
      .busy(div_busy), .done(div_done), .quo(div_q));

   mapper_acc #(.IDX_W(IDX_W), .TS_W(TS_W), .R_W(R_W), .RF_W(RF_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .load(div_done), .ratio(ratio),
      .load_ratio(div_q), .base_time(prev_time), .base_idx(prev_idx),
      .idx(smp_idx), .ts(ts_out));

   mapper_hold #(.HC_W(HC_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(acc_ok), .stb(smp_stb),
      .limit(hold_limit), .expired(hold_exp));

   mapper_sat #(.IN_W(TS_W + 1), .OUT_W(RES_W)) u_sat (
      .d(diff), .q(resid_sat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_UNLOCK;
         seen      <= 2'd0;
         coef_ok   <= 1'b0;
         prev_idx  <= '0;
         prev_time <= '0;
         ratio     <= '0;
         resid     <= '0;
         resid_vld <= 1'b0;
         err_cnt   <= '0;
      end else begin
         resid_vld <= acc_ok && coef_ok;
         if (acc_ok && coef_ok)
            resid <= RES_W'(resid_sat);
         if (acc_ok) begin
            prev_idx  <= anc_idx;
            prev_time <= anc_time;
            if (seen != 2'd2)
               seen <= seen + 1'b1;
         end
         if (zero_rej && err_cnt != '1)
            err_cnt <= err_cnt + 1'b1;
         if (div_done) begin
            ratio   <= div_q;
            coef_ok <= 1'b1;
         end
         if (acc_ok && coef_ok)
            st <= ST_LOCK;
         else if (div_done && st == ST_UNLOCK)
            st <= ST_LOCK;
         else if (st == ST_LOCK && hold_exp)
            st <= ST_HOLD;
      end
   end

   assign ts_valid  = (st != ST_UNLOCK);
   assign map_state = st;

   a_r4_valid_after_two: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid |-> (seen == 2'd2));

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      resid_vld |=> !resid_vld);

   a_r6_err_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (err_cnt >= $past(err_cnt)));

   a_r8_hold_from_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && $past(st) != ST_HOLD) |-> ($past(st) == ST_LOCK));

   a_r9_anchor_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && anc_vld && !upd_busy && delta_n != '0) |=> (st == ST_LOCK));

endmodule

// File: tb/test_stamp_mapper.sv
`timescale 1ns/1ps
module test_stamp_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stb = 1'b0;
   logic        avld = 1'b0;
   logic [31:0] aidx = '0;
   logic [47:0] atime = '0;
   logic [15:0] hlim = 16'd1000;
   logic [31:0] sidx;
   logic [47:0] ts;
   logic        tsv;
   logic [31:0] res;
   logic        resv;
   logic [1:0]  st;
   logic [7:0]  err;

   int total = 0;
   int bad = 0;

   logic [31:0] m_idx = '0;
   logic [47:0] m_t = '0;
   logic [47:0] m_ratio = '0;
   logic        m_coef = 1'b0;
   int          m_seen = 0;
   logic [31:0] m_n = '0;
   logic [7:0]  m_err = '0;

   always #4 clk = ~clk;

   stamp_mapper i_stamp_mapper (
      .clk(clk), .rst_n(rst_n), .smp_stb(stb), .anc_vld(avld), .anc_idx(aidx),
      .anc_time(atime), .hold_limit(hlim), .smp_idx(sidx), .ts_out(ts),
      .ts_valid(tsv), .resid(res), .resid_vld(resv), .map_state(st), .err_cnt(err));

   task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [47:0] f_pred(input logic [31:0] n);
      logic [31:0] dn;
      logic [79:0] a;
      dn = n - m_idx;
      a = {m_t, 32'b0} + 80'(m_ratio) * 80'(dn);
      return a[79:32];
   endfunction

   function automatic logic [31:0] f_sat(input logic [47:0] t, input logic [47:0] p);
      longint d;
      d = longint'({16'b0, t}) - longint'({16'b0, p});
      if (d > 64'sd2147483647) return 32'h7fffffff;
      if (d < -64'sd2147483648) return 32'h80000000;
      return d[31:0];
   endfunction

   task automatic strobes(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk) stb = 1'b1;
         @(negedge clk) stb = 1'b0;
         m_n = m_n + 1;
      end
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic anchor(input logic [31:0] i, input logic [47:0] t, input string tag);
      logic        exp_v;
      logic [31:0] exp_r;
      logic [79:0] q;
      exp_v = 1'b0;
      exp_r = '0;
      if (m_seen > 0 && i == m_idx) begin
         if (m_err != 8'hff) m_err = m_err + 1;
      end else begin
         exp_v = m_coef;
         if (m_coef) exp_r = f_sat(t, f_pred(i));
         if (m_seen > 0) begin
            q = {t - m_t, 32'b0} / 80'(i - m_idx);
            m_ratio = q[47:0];
            m_coef = 1'b1;
         end
         m_idx = i;
         m_t = t;
         m_seen++;
      end
      @(negedge clk) begin avld = 1'b1; aidx = i; atime = t; end
      @(negedge clk) avld = 1'b0;
      chk({tag, " resid_vld"}, 80'(resv), 80'(exp_v));
      if (exp_v) chk({tag, " resid"}, 80'(res), 80'(exp_r));
      chk({tag, " err_cnt"}, 80'(err), 80'(m_err));
   endtask

   task automatic t_reset;
      chk("R1 state", 80'(st), 80'd0);
      chk("R1 ts_valid", 80'(tsv), 80'd0);
      chk("R1 resid_vld", 80'(resv), 80'd0);
      chk("R1 smp_idx", 80'(sidx), 80'd0);
      chk("R1 err_cnt", 80'(err), 80'd0);
   endtask

   task automatic t_unlocked;
      strobes(5);
      chk("R2 index counts strobes", 80'(sidx), 80'(m_n));
      chk("R4 invalid before anchors", 80'(tsv), 80'd0);
      anchor(m_n, 48'd5000, "R5 first anchor no residual");
      idle(100);
      chk("R4 one anchor stays unlocked", 80'(st), 80'd0);
      anchor(m_n, 48'd5100, "R6 zero delta rejected");
      chk("R6 state unchanged", 80'(st), 80'd0);
   endtask

   task automatic t_lock_and_busy;
      strobes(100);
      anchor(m_n, 48'd6000, "R5 second anchor no residual");
      @(negedge clk) begin avld = 1'b1; aidx = m_n + 1; atime = 48'd9999; end
      @(negedge clk) avld = 1'b0;
      chk("R7 busy anchor no residual", 80'(resv), 80'd0);
      chk("R7 busy anchor no error", 80'(err), 80'(m_err));
      idle(100);
      chk("R4 locked after two anchors", 80'(st), 80'd1);
      chk("R4 ts valid", 80'(tsv), 80'd1);
      chk("R3 ts at anchor", 80'(ts), 80'(f_pred(m_n)));
      strobes(3);
      chk("R2 ts advances by ratio", 80'(ts), 80'(f_pred(m_n)));
      chk("R2 index", 80'(sidx), 80'(m_n));
   endtask

   task automatic t_coincident;
      anchor(m_n, f_pred(m_n) + 48'd1, "R5 positive residual");
      @(negedge clk) stb = 1'b1;
      repeat (100) @(negedge clk);
      stb = 1'b0;
      m_n = m_n + 100;
      chk("R10 index across reload", 80'(sidx), 80'(m_n));
      chk("R10 ts across reload", 80'(ts), 80'(f_pred(m_n)));
      strobes(7);
      chk("R3 fractional ratio ts", 80'(ts), 80'(f_pred(m_n)));
   endtask

   task automatic t_negative;
      anchor(m_n, f_pred(m_n) - 48'd7, "R5 negative residual");
      idle(100);
      strobes(2);
      chk("R3 ts after update", 80'(ts), 80'(f_pred(m_n)));
   endtask

   task automatic t_hold;
      anchor(m_n, f_pred(m_n) + 48'd2, "R5 pre-hold anchor");
      idle(100);
      hlim = 16'd20;
      strobes(19);
      idle(2);
      chk("R8 still locked below limit", 80'(st), 80'd1);
      strobes(1);
      idle(2);
      chk("R8 holdover at limit", 80'(st), 80'd2);
      chk("R8 ts valid in holdover", 80'(tsv), 80'd1);
      strobes(5);
      chk("R8 frozen ratio ts", 80'(ts), 80'(f_pred(m_n)));
      anchor(m_n, f_pred(m_n) + 48'd3, "R9 anchor in holdover");
      chk("R9 relocked", 80'(st), 80'd1);
      idle(100);
      chk("R9 count restarted", 80'(st), 80'd1);
   endtask

   task automatic t_saturate;
      hlim = 16'd1000;
      strobes(4);
      anchor(m_n, f_pred(m_n) + 48'h100_0000_0000, "R11 residual clipped high");
      chk("R11 clip value", 80'(res), 80'h7fffffff);
      idle(100);
   endtask

   task automatic finish_up;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #200000;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_unlocked();
      t_lock_and_busy();
      t_coincident();
      t_negative();
      t_hold();
      t_saturate();
      finish_up();
   end
endmodule